// File: doc/BRIEF.md
# Descriptor Ownership Suspend Controller

This block is the control unit of one channel (transmit or receive) of a descriptor-based packet DMA engine. It holds the start address of a descriptor ring and a current-descriptor pointer. For each descriptor it reads the first descriptor word over a memory read port and inspects its ownership flag. A descriptor that belongs to the DMA is handed to the channel's datapath. The pointer then steps to the next descriptor, or back to the ring base at the end of the ring. A descriptor that still belongs to the host puts the channel into a suspended state and sets a sticky "descriptor unavailable" status bit.

Software controls the channel through a small register port. It has a start bit and a self-clearing soft-reset bit. It has a list base register that accepts writes only while the channel is stopped. It has a poll-demand register: a write of any value to it wakes a suspended channel, and the channel then fetches the current descriptor again. A transmit channel also suspends when the datapath reports an underflow. The memory request, memory response and descriptor hand-off are valid/ready streams. A request or an offered descriptor keeps valid high and its payload steady until it is accepted. The one exception is a stop: it withdraws an offered descriptor. The block never withdraws a memory request and always takes the response that belongs to one. Register and status pins are plain, with no handshake.

Top module: `dsc_own_ctrl`

## Requirements
- R1: After rst_n, or after a write to CTRL (address 0) with bit 1 set, all registers read zero and the channel is stopped. During a soft reset, CTRL bit 1 reads 1 for RST_CYCLES cycles and then clears by itself.
- R2: A write to BASE (address 2) stores the address with its low bits forced to zero. Bits 1:0 are dropped for a 32-bit bus, bits 2:0 for 64-bit and bits 3:0 for 128-bit. The dropped bits read as zero.
- R3: While CTRL bit 0 (start) is 1, writes to BASE are ignored.
- R4: When start goes from 0 to 1, the pointer CUR (address 4, read-only) is loaded from BASE if BASE was written since the last load. Otherwise it keeps its previous value. The channel then requests the word at CUR.
- R5: A memory request holds mem_req_valid high and mem_req_addr unchanged until mem_req_ready is seen.
- R6: A response with bit 31 = 0 (host-owned) suspends the channel: no further request is made. The response also sets the unavailable bit in STATUS (address 3): bit 2 for transmit, bit 7 for receive. STATUS bits are sticky, and writing 1 to a bit clears it. Writing 0 has no effect.
- R7: A response with bit 31 = 1 offers the descriptor on desc_valid, with desc_addr = CUR and desc_word = the fetched word. On acceptance the pointer advances by 16 bytes, or returns to BASE when bit 30 (end of ring) was set. The next request follows.
- R8: A write of any value to POLL (address 1) is accepted only while the channel is suspended or running. A suspended channel then fetches the same CUR again. A demand made while stopped has no effect. POLL always reads zero.
- R9: On a transmit channel, tx_underflow while a descriptor is offered suspends the channel and sets STATUS bit 5. CUR is left unchanged, so a later poll demand fetches the same descriptor again.
- R10: Clearing start stops the channel: an offered descriptor is withdrawn and no new request is made. A request already issued still completes, and its response is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address (0 CTRL, 1 POLL, 2 BASE, 3 STATUS) |
| reg_wr_data | input | REG_W | Register write data |
| reg_rd_addr | input | 3 | Register read address (0..4) |
| reg_rd_data | output | REG_W | Register read data, combinational |
| mem_req_valid | output | 1 | Descriptor word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | REG_W | Address of the descriptor word |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Block waits for a response |
| mem_rsp_data | input | REG_W | First descriptor word (bit 31 own, bit 30 end of ring) |
| desc_valid | output | 1 | DMA-owned descriptor offered to the datapath |
| desc_ready | input | 1 | Datapath has finished the descriptor |
| desc_addr | output | REG_W | Address of the offered descriptor |
| desc_word | output | REG_W | First word of the offered descriptor |
| tx_underflow | input | 1 | Underflow from the transmit datapath (ignored on receive) |

## Verification
A register write takes effect at the next clock edge, so the bench reads register values back combinationally one sample later. A request follows a start or an accepted poll demand one further edge later, because the state register sits between them. The bench therefore waits for mem_req_valid and bounds the wait, instead of fixing the cycle. Suspension is checked by sampling for several cycles that no request appears. Each handshake is driven and sampled on the falling edge, and the results of an accepted beat are checked only after the next rising edge.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_STOPPED   = 3'd0,
    ST_FETCH     = 3'd1,
    ST_CHECK_OWN = 3'd2,
    ST_RUN       = 3'd3,
    ST_SUSPENDED = 3'd4
  } dsc_state_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_POLL = 3'd1;
  localparam logic [2:0] RA_BASE = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_CUR  = 3'd4;

  localparam int CTRL_START  = 0;
  localparam int CTRL_SRST   = 1;
  localparam int OWN_BIT     = 31;
  localparam int EOR_BIT     = 30;
  localparam int UNF_BIT     = 5;
  localparam int TX_UNAV_BIT = 2;
  localparam int RX_UNAV_BIT = 7;

  function automatic int lsb_drop(input int bus_w);
    if (bus_w >= 128) return 4;
    else if (bus_w >= 64) return 3;
    else return 2;
  endfunction
endpackage

// File: rtl/dsc_regs.sv
module dsc_regs
  import dsc_pkg::*;
#(
  parameter bit IS_TX      = 1'b1,
  parameter int REG_W      = 32,
  parameter int BUS_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic [REG_W-1:0] cur_ptr,
  input  logic             set_unav,
  input  logic             set_unf,
  input  logic             poll_ok,
  input  logic             poll_take,
  input  logic             load_take,
  output logic             start,
  output logic [REG_W-1:0] base,
  output logic             base_dirty,
  output logic             poll_pend,
  output logic             srst_active
);
  localparam int LSB      = lsb_drop(BUS_W);
  localparam int CNT_W    = $clog2(RST_CYCLES + 1);
  localparam int UNAV_BIT = IS_TX ? TX_UNAV_BIT : RX_UNAV_BIT;
  localparam logic [REG_W-1:0] BASE_MASK = {REG_W{1'b1}} << LSB;
  localparam logic [CNT_W-1:0] CNT_LOAD  = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] srst_cnt;
  logic             unav_q;
  logic             unf_q;
  logic             wr_ctrl, wr_poll, wr_base, wr_stat;

  assign srst_active = (srst_cnt != '0);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL) && !srst_active;
  assign wr_poll = wr_en && (wr_addr == RA_POLL) && !srst_active;
  assign wr_base = wr_en && (wr_addr == RA_BASE) && !srst_active && !start;
  assign wr_stat = wr_en && (wr_addr == RA_STAT) && !srst_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt   <= '0;
      start      <= 1'b0;
      base       <= '0;
      base_dirty <= 1'b0;
      poll_pend  <= 1'b0;
      unav_q     <= 1'b0;
      unf_q      <= 1'b0;
    end else if (srst_active || (wr_ctrl && wr_data[CTRL_SRST])) begin
      srst_cnt   <= srst_active ? srst_cnt - 1'b1 : CNT_LOAD;
      start      <= 1'b0;
      base       <= '0;
      base_dirty <= 1'b0;
      poll_pend  <= 1'b0;
      unav_q     <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      if (wr_ctrl) start <= wr_data[CTRL_START];
      if (wr_base) base <= wr_data & BASE_MASK;
      if (wr_base) base_dirty <= 1'b1;
      else if (load_take) base_dirty <= 1'b0;
      poll_pend <= (poll_pend && !poll_take) || (wr_poll && poll_ok);
      unav_q <= (unav_q && !(wr_stat && wr_data[UNAV_BIT])) || set_unav;
      unf_q  <= (unf_q && !(wr_stat && wr_data[UNF_BIT])) || (set_unf && IS_TX);
    end
  end

  logic [REG_W-1:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[UNAV_BIT] = unav_q;
    stat_word[UNF_BIT]  = unf_q;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: begin
        rd_data[CTRL_START] = start;
        rd_data[CTRL_SRST]  = srst_active;
      end
      RA_BASE: rd_data = base;
      RA_STAT: rd_data = stat_word;
      RA_CUR:  rd_data = cur_ptr;
      default: rd_data = '0;
    endcase
  end

  p_base_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (base & ~BASE_MASK) == '0);

  p_base_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !srst_active && !(wr_en && wr_addr == RA_CTRL)) |=> $stable(base));

  p_srst_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    srst_active |-> (!start && base == '0 && !unav_q && !unf_q && !poll_pend));

  p_srst_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_active && !(wr_en && wr_addr == RA_CTRL)) |=> (srst_cnt < $past(srst_cnt)));
endmodule

// File: rtl/dsc_ptr.sv
module dsc_ptr
  import dsc_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             load,
  input  logic             base_dirty,
  input  logic [REG_W-1:0] base,
  input  logic             adv,
  input  logic             wrap,
  output logic [REG_W-1:0] cur
);
  localparam logic [REG_W-1:0] STEP = REG_W'(DESC_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (srst) cur <= '0;
    else if (load && base_dirty) cur <= base;
    else if (adv) cur <= wrap ? base : cur + STEP;
  end

  p_wrap_base_r7: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (adv && wrap && !load) |=> (cur == $past(base)));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (adv && !wrap && !load) |=> (cur - $past(cur) == STEP));
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             start,
  input  logic             poll_pend,
  input  logic             underflow,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [REG_W-1:0] mem_rsp_data,
  input  logic             desc_ready,
  output logic             mem_req_valid,
  output logic             mem_rsp_ready,
  output logic             desc_valid,
  output logic [REG_W-1:0] desc_word,
  output logic             poll_ok,
  output logic             poll_take,
  output logic             load_take,
  output logic             adv,
  output logic             wrap,
  output logic             set_unav,
  output logic             set_unf
);
  dsc_state_e st_q, st_d;
  logic       eor_q;
  logic       unf_in;

  generate
    if (IS_TX) begin : g_tx
      assign unf_in = underflow;
    end else begin : g_rx
      assign unf_in = 1'b0 & underflow;
    end
  endgenerate

  assign mem_req_valid = (st_q == ST_FETCH);
  assign mem_rsp_ready = (st_q == ST_CHECK_OWN);
  assign desc_valid    = (st_q == ST_RUN) && start;
  assign poll_ok       = (st_q == ST_RUN) || (st_q == ST_SUSPENDED);
  assign wrap          = eor_q;

  always_comb begin
    st_d      = st_q;
    poll_take = 1'b0;
    load_take = 1'b0;
    adv       = 1'b0;
    set_unav  = 1'b0;
    set_unf   = 1'b0;
    case (st_q)
      ST_STOPPED: if (start) begin
        st_d      = ST_FETCH;
        load_take = 1'b1;
        poll_take = 1'b1;
      end
      ST_FETCH: if (mem_req_ready) st_d = ST_CHECK_OWN;
      ST_CHECK_OWN: if (mem_rsp_valid) begin
        if (!start) st_d = ST_STOPPED;
        else if (mem_rsp_data[OWN_BIT]) st_d = ST_RUN;
        else begin
          st_d     = ST_SUSPENDED;
          set_unav = 1'b1;
        end
      end
      ST_RUN: begin
        if (!start) st_d = ST_STOPPED;
        else if (unf_in) begin
          st_d    = ST_SUSPENDED;
          set_unf = 1'b1;
        end else if (desc_ready) begin
          st_d      = ST_FETCH;
          adv       = 1'b1;
          poll_take = 1'b1;
        end
      end
      ST_SUSPENDED: begin
        if (!start) st_d = ST_STOPPED;
        else if (poll_pend) begin
          st_d      = ST_FETCH;
          poll_take = 1'b1;
        end
      end
      default: st_d = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_STOPPED;
      eor_q     <= 1'b0;
      desc_word <= '0;
    end else if (srst) begin
      st_q      <= ST_STOPPED;
      eor_q     <= 1'b0;
      desc_word <= '0;
    end else begin
      st_q <= st_d;
      if (mem_rsp_ready && mem_rsp_valid) begin
        desc_word <= mem_rsp_data;
        eor_q     <= mem_rsp_data[EOR_BIT];
      end
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);

  p_unav_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (mem_rsp_ready && mem_rsp_valid && !mem_rsp_data[OWN_BIT] && start)
      |=> (st_q == ST_SUSPENDED && !mem_req_valid));

  p_susp_wait_r8: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (st_q == ST_SUSPENDED && !poll_pend && start) |=> (st_q == ST_SUSPENDED));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (!start && (st_q == ST_RUN || st_q == ST_SUSPENDED)) |=> (st_q == ST_STOPPED));

  p_unf_r9: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (desc_valid && unf_in) |=> (st_q == ST_SUSPENDED || !start));
endmodule

// File: rtl/dsc_own_ctrl.sv
module dsc_own_ctrl
  import dsc_pkg::*;
#(
  parameter bit IS_TX      = 1'b1,
  parameter int REG_W      = 32,
  parameter int BUS_W      = 32,
  parameter int DESC_BYTES = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_wr_addr,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [2:0]       reg_rd_addr,
  output logic [REG_W-1:0] reg_rd_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [REG_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [REG_W-1:0] mem_rsp_data,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic [REG_W-1:0] desc_addr,
  output logic [REG_W-1:0] desc_word,
  input  logic             tx_underflow
);
  logic             start, base_dirty, poll_pend, srst_active;
  logic [REG_W-1:0] base, cur;
  logic             set_unav, set_unf, poll_ok, poll_take, load_take, adv, wrap;

  dsc_regs #(
    .IS_TX(IS_TX), .REG_W(REG_W), .BUS_W(BUS_W), .RST_CYCLES(RST_CYCLES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .cur_ptr(cur), .set_unav(set_unav), .set_unf(set_unf),
    .poll_ok(poll_ok), .poll_take(poll_take), .load_take(load_take),
    .start(start), .base(base), .base_dirty(base_dirty),
    .poll_pend(poll_pend), .srst_active(srst_active)
  );

  dsc_ptr #(.REG_W(REG_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .srst(srst_active),
    .load(load_take), .base_dirty(base_dirty), .base(base),
    .adv(adv), .wrap(wrap), .cur(cur)
  );

  dsc_fsm #(.IS_TX(IS_TX), .REG_W(REG_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .srst(srst_active),
    .start(start), .poll_pend(poll_pend), .underflow(tx_underflow),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .desc_ready(desc_ready),
    .mem_req_valid(mem_req_valid), .mem_rsp_ready(mem_rsp_ready),
    .desc_valid(desc_valid), .desc_word(desc_word),
    .poll_ok(poll_ok), .poll_take(poll_take), .load_take(load_take),
    .adv(adv), .wrap(wrap), .set_unav(set_unav), .set_unf(set_unf)
  );

  assign mem_req_addr = cur;
  assign desc_addr    = cur;

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || srst_active)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  p_desc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || srst_active)
    (desc_valid && !desc_ready && !tx_underflow) |=> (!desc_valid || $stable(desc_addr)));
endmodule

// File: tb/sim_dsc_own_ctrl.sv
module sim_dsc_own_ctrl;
  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        mem_req_valid, mem_rsp_ready, desc_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        desc_ready = 1'b0;
  logic        tx_underflow = 1'b0;
  logic [31:0] mem_req_addr, desc_addr, desc_word;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsc_own_ctrl #(.IS_TX(1'b1), .REG_W(32), .BUS_W(32), .DESC_BYTES(16), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_word(desc_word), .tx_underflow(tx_underflow)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      checks = checks + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] align32(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_rd_addr = a;
    #0.5;
    chk(reg_rd_data == exp, tag, reg_rd_data, exp);
  endtask

  task automatic no_req(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!mem_req_valid && !desc_valid, tag, {30'd0, desc_valid, mem_req_valid}, 32'd0);
    end
  endtask

  task automatic serve(input logic [31:0] exp, input logic own, input logic eor, input string tag);
    int n = 0;
    logic [31:0] word;
    while (!mem_req_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(mem_req_valid == 1'b1, {tag, " request"}, {31'd0, mem_req_valid}, 32'd1);
    chk(mem_req_addr == exp, {tag, " addr"}, mem_req_addr, exp);
    for (int k = 0; k < int'($urandom % 3); k++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == exp, "R5 request held", mem_req_addr, exp);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int k = 0; k < int'($urandom % 3); k++) @(negedge clk);
    word = {own, eor, 30'($urandom)};
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = word;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (own) begin
      chk(desc_valid && desc_addr == exp, "R7 desc offered", desc_addr, exp);
      chk(desc_word == word, "R7 desc word", desc_word, word);
    end
  endtask

  task automatic take_desc();
    for (int k = 0; k < int'($urandom % 3); k++) @(negedge clk);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
  endtask

  logic [31:0] exp_ptr;
  logic [31:0] base_v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk(3'd0, 32'd0, "R1 ctrl after reset");
    rd_chk(3'd2, 32'd0, "R1 base after reset");
    rd_chk(3'd3, 32'd0, "R1 status after reset");
    rd_chk(3'd4, 32'd0, "R1 cur after reset");
    chk(!mem_req_valid, "R1 no request after reset", {31'd0, mem_req_valid}, 32'd0);

    wr(3'd2, 32'h0000_1003);
    rd_chk(3'd2, 32'h0000_1000, "R2 base low bits dropped");
    wr(3'd0, 32'h1);
    @(negedge clk);
    rd_chk(3'd4, 32'h0000_1000, "R4 cur loaded from base");
    wr(3'd2, 32'h0000_2000);
    rd_chk(3'd2, 32'h0000_1000, "R3 base write ignored while running");

    serve(32'h1000, 1'b0, 1'b0, "R4 first fetch");
    @(negedge clk);
    rd_chk(3'd3, 32'h4, "R6 unavailable bit 2 set");
    no_req(5, "R6 suspended");
    wr(3'd3, 32'h0);
    rd_chk(3'd3, 32'h4, "R6 write 0 keeps status");
    wr(3'd3, 32'h4);
    rd_chk(3'd3, 32'h0, "R6 write 1 clears");
    rd_chk(3'd1, 32'h0, "R8 poll reads zero");
    wr(3'd1, 32'h0000_ABCD);
    rd_chk(3'd1, 32'h0, "R8 poll reads zero after write");

    exp_ptr = 32'h1000;
    base_v  = 32'h1000;
    for (int it = 0; it < 40; it++) begin
      logic own, eor;
      own = (($urandom % 5) != 0);
      eor = own && (($urandom % 6) == 0);
      serve(exp_ptr, own, eor, "R8 R7 fetch");
      if (own) begin
        take_desc();
        exp_ptr = eor ? base_v : exp_ptr + 32'd16;
      end else begin
        @(negedge clk);
        rd_chk(3'd3, 32'h4, "R6 unavailable in loop");
        no_req(2, "R6 suspended in loop");
        wr(3'd3, 32'h4);
        wr(3'd1, $urandom);
      end
    end

    serve(exp_ptr, 1'b1, 1'b0, "R9 pre-underflow fetch");
    @(negedge clk);
    tx_underflow = 1'b1;
    @(negedge clk);
    tx_underflow = 1'b0;
    no_req(4, "R9 suspended on underflow");
    rd_chk(3'd3, 32'h20, "R9 underflow bit 5");
    rd_chk(3'd4, exp_ptr, "R9 cur unchanged");
    wr(3'd3, 32'h20);
    wr(3'd1, 32'h1);
    serve(exp_ptr, 1'b1, 1'b0, "R9 refetch same descriptor");
    take_desc();
    exp_ptr = exp_ptr + 32'd16;

    serve(exp_ptr, 1'b1, 1'b0, "R10 fetch before stop");
    wr(3'd0, 32'h0);
    no_req(5, "R10 stopped");
    wr(3'd1, 32'h5);
    no_req(4, "R8 poll ignored while stopped");
    wr(3'd2, 32'h0000_3006);
    rd_chk(3'd2, align32(32'h0000_3006), "R2 base written while stopped");
    wr(3'd0, 32'h1);
    @(negedge clk);
    rd_chk(3'd4, 32'h3004, "R4 new base loaded");
    serve(32'h3004, 1'b1, 1'b0, "R4 fetch at new base");
    take_desc();
    serve(32'h3014, 1'b1, 1'b0, "R7 step");
    wr(3'd0, 32'h0);
    no_req(3, "R10 stopped again");
    wr(3'd0, 32'h1);
    @(negedge clk);
    rd_chk(3'd4, 32'h3014, "R4 resume without base write");
    serve(32'h3014, 1'b1, 1'b1, "R4 resume fetch");
    take_desc();
    serve(32'h3004, 1'b1, 1'b0, "R7 end of ring wraps to base");

    wr(3'd0, 32'h3);
    rd_chk(3'd0, 32'h2, "R1 soft reset bit reads 1");
    chk(!desc_valid, "R1 desc withdrawn by soft reset", {31'd0, desc_valid}, 32'd0);
    repeat (RSTC + 1) @(negedge clk);
    rd_chk(3'd0, 32'h0, "R1 soft reset bit self-clears");
    rd_chk(3'd2, 32'h0, "R1 base cleared by soft reset");
    rd_chk(3'd4, 32'h0, "R1 cur cleared by soft reset");
    rd_chk(3'd3, 32'h0, "R1 status cleared by soft reset");
    no_req(3, "R1 stopped after soft reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule